// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock. It is controlled only through magic 16-bit key values that software writes to a write-only key register. There is no enable bit. One key starts the timer, and once it is running nothing short of a system reset stops it. A second key reloads the down-counter (a refresh). A third key opens write access to the prescaler and reload registers, and any other key closes it again. When the 12-bit counter runs out, the block raises a one-cycle reset request and starts a new period.

Register accesses arrive on a simple single-cycle bus in the bus clock domain. Prescaler and reload updates are carried into the watchdog clock domain by a toggle handshake. Each register has a busy flag in the status register, and that flag stays set until the watchdog domain has acknowledged the update. The values read back from the prescaler and reload registers come from the watchdog domain, so they are only meaningful while the matching busy flag is clear.

Top module: `wdg_top`

## Requirements
- R1: Until the key 0xCCCC has been written to the key register (offset 0), the counter does not run and no reset request is raised.
- R2: Once started, the watchdog keeps running and raising requests whatever keys or register writes follow.
- R3: Writing key 0xAAAA reloads the counter from the reload value. Refreshes issued more often than the timeout keep the reset request low.
- R4: Reading the key register (offset 0) returns 0.
- R5: After reset, the prescaler code reads 0, the reload value reads 0xFFF and the status register reads 0.
- R6: After key 0x5555, writes to the prescaler (offset 2, bits 2:0) and to the reload register (offset 1, bits 11:0) are accepted. Status register (offset 3) bit 0 is the prescaler busy flag and bit 1 is the reload busy flag. A flag reads 1 in the cycle after its accepted write and clears when the handshake completes. After that, the new value reads back.
- R7: Any key other than 0x5555 re-locks both registers. A write while locked sets no busy flag and leaves the value unchanged.
- R8: A write to the prescaler or reload register while its own busy flag is set is ignored.
- R9: Reset requests repeat every (reload+1)*D watchdog clock cycles. D is 4 << code for prescaler codes 0 to 6, and 256 for code 7.
- R10: Each reset request lasts exactly one watchdog clock cycle. The counter reloads in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low system reset for both domains |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational from offset) |
| wdgClk | input | 1 | Independent watchdog clock |
| wdgRstReq | output | 1 | Reset request, one watchdog cycle wide |

## Verification
A wrong counter or prescaler state shows directly in the spacing of reset requests. The bench therefore measures every interval between requests in watchdog cycles against (reload+1)*D, so a divider or reload error shows within one period. A lost handshake toggle leaves a busy flag stuck high, or the readback stale, within a few cycles of the write. A lock that fails to engage shows as a busy flag in the very next bus cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W     = 16;
  localparam int CNT_W     = 12;
  localparam int PRE_W     = 3;
  localparam int PRE_CNT_W = 8;
  localparam int ADDR_W    = 2;

  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_KEY  = 2'd0,
    ADDR_RLD  = 2'd1,
    ADDR_PRE  = 2'd2,
    ADDR_STAT = 2'd3
  } regAddr_e;

  // bus domain -> watchdog domain
  typedef struct packed {
    logic             started;
    logic             feedTgl;
    logic             preTgl;
    logic             rldTgl;
    logic [PRE_W-1:0] preData;
    logic [CNT_W-1:0] rldData;
  } xfer_t;

  // watchdog domain -> bus domain
  typedef struct packed {
    logic             preAckTgl;
    logic             rldAckTgl;
    logic [PRE_W-1:0] preVal;
    logic [CNT_W-1:0] rldVal;
  } ack_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                busClk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [KEY_W-1:0]    busWdata,
  output logic [KEY_W-1:0]    busRdata,
  output xfer_t               toCore,
  input  ack_t                fromCore
);
  logic unlocked;
  logic [SYNC_STAGES-1:0] preAckSync;
  logic [SYNC_STAGES-1:0] rldAckSync;
  logic preBusy;
  logic rldBusy;
  logic wrEn;

  assign wrEn    = busSel && busWrite;
  assign preBusy = toCore.preTgl ^ preAckSync[SYNC_STAGES-1];
  assign rldBusy = toCore.rldTgl ^ rldAckSync[SYNC_STAGES-1];

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      preAckSync <= '0;
      rldAckSync <= '0;
    end else begin
      preAckSync <= {preAckSync[SYNC_STAGES-2:0], fromCore.preAckTgl};
      rldAckSync <= {rldAckSync[SYNC_STAGES-2:0], fromCore.rldAckTgl};
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      unlocked       <= 1'b0;
      toCore.started <= 1'b0;
      toCore.feedTgl <= 1'b0;
      toCore.preTgl  <= 1'b0;
      toCore.rldTgl  <= 1'b0;
      toCore.preData <= '0;
      toCore.rldData <= '1;
    end else if (wrEn) begin
      unique case (regAddr_e'(busAddr))
        ADDR_KEY: begin
          unlocked <= (busWdata == KEY_UNLOCK);
          if (busWdata == KEY_START) toCore.started <= 1'b1;
          if (busWdata == KEY_FEED)  toCore.feedTgl <= ~toCore.feedTgl;
        end
        ADDR_PRE: if (unlocked && !preBusy) begin
          toCore.preData <= busWdata[PRE_W-1:0];
          toCore.preTgl  <= ~toCore.preTgl;
        end
        ADDR_RLD: if (unlocked && !rldBusy) begin
          toCore.rldData <= busWdata[CNT_W-1:0];
          toCore.rldTgl  <= ~toCore.rldTgl;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (regAddr_e'(busAddr))
      ADDR_KEY:  busRdata = '0;
      ADDR_PRE:  busRdata = {{(KEY_W-PRE_W){1'b0}}, fromCore.preVal};
      ADDR_RLD:  busRdata = {{(KEY_W-CNT_W){1'b0}}, fromCore.rldVal};
      ADDR_STAT: busRdata = {{(KEY_W-2){1'b0}}, rldBusy, preBusy};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  wdgClk,
  input  logic  rstN,
  input  xfer_t toCore,
  output ack_t  fromCore,
  output logic  wdgRstReq
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] stg [SYNC_STAGES];
  logic [NSIG-1:0] syncd;
  logic [NSIG-1:0] prevS;
  logic startEdge, feedEdge, preEdge, rldEdge, running;
  logic [PRE_W-1:0]     preReg;
  logic [CNT_W-1:0]     rldReg;
  logic [CNT_W-1:0]     cnt;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLim;

  function automatic logic [PRE_CNT_W-1:0] limitOf(input logic [PRE_W-1:0] code);
    logic [PRE_CNT_W:0] d;
    d = (code >= PRE_W'(6)) ? (PRE_CNT_W+1)'(256) : ((PRE_CNT_W+1)'(4) << code);
    return PRE_CNT_W'(d - 1'b1);
  endfunction

  always_ff @(posedge wdgClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      prevS <= '0;
    end else begin
      stg[0] <= {toCore.started, toCore.feedTgl, toCore.preTgl, toCore.rldTgl};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      prevS <= syncd;
    end
  end

  assign syncd     = stg[SYNC_STAGES-1];
  assign running   = syncd[3];
  assign startEdge = syncd[3] & ~prevS[3];
  assign feedEdge  = syncd[2] ^ prevS[2];
  assign preEdge   = syncd[1] ^ prevS[1];
  assign rldEdge   = syncd[0] ^ prevS[0];
  assign preLim    = limitOf(preReg);

  // register capture and acknowledge
  always_ff @(posedge wdgClk or negedge rstN) begin
    if (!rstN) begin
      preReg <= '0;
      rldReg <= '1;
      fromCore.preAckTgl <= 1'b0;
      fromCore.rldAckTgl <= 1'b0;
    end else begin
      if (preEdge) preReg <= toCore.preData;
      if (rldEdge) rldReg <= toCore.rldData;
      fromCore.preAckTgl <= syncd[1];
      fromCore.rldAckTgl <= syncd[0];
    end
  end

  assign fromCore.preVal = preReg;
  assign fromCore.rldVal = rldReg;

  // prescaler and down-counter
  always_ff @(posedge wdgClk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '1;
      preCnt    <= '0;
      wdgRstReq <= 1'b0;
    end else begin
      wdgRstReq <= 1'b0;
      if (startEdge || (feedEdge && running)) begin
        cnt    <= rldReg;
        preCnt <= '0;
      end else if (running) begin
        if (preCnt >= preLim) begin
          preCnt <= '0;
          if (cnt == '0) begin
            wdgRstReq <= 1'b1;
            cnt       <= rldReg;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  busWdata,
  output logic [KEY_W-1:0]  busRdata,
  input  logic              wdgClk,
  output logic              wdgRstReq
);
  xfer_t toCore;
  ack_t  fromCore;

  wdg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .busClk(busClk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .toCore(toCore), .fromCore(fromCore)
  );

  wdg_core #(.SYNC_STAGES(SYNC_STAGES)) core_i (
    .wdgClk(wdgClk), .rstN(rstN), .toCore(toCore),
    .fromCore(fromCore), .wdgRstReq(wdgRstReq)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
(
  input logic              busClk,
  input logic              wdgClk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [KEY_W-1:0]  busRdata,
  input logic              wdgRstReq,
  input xfer_t             toCore,
  input ack_t              fromCore
);
  assert_key_reads_zero_R4: assert property (@(posedge busClk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == ADDR_KEY) |-> busRdata == '0);

  assert_start_sticky_R2: assert property (@(posedge busClk) disable iff (!rstN)
    toCore.started |=> toCore.started);

  assert_rld_data_held_R8: assert property (@(posedge busClk) disable iff (!rstN)
    (toCore.rldTgl != fromCore.rldAckTgl) |=> $stable(toCore.rldData));

  assert_pre_data_held_R8: assert property (@(posedge busClk) disable iff (!rstN)
    (toCore.preTgl != fromCore.preAckTgl) |=> $stable(toCore.preData));

  assert_no_req_unstarted_R1: assert property (@(posedge wdgClk) disable iff (!rstN)
    !toCore.started |-> !wdgRstReq);

  assert_req_single_R10: assert property (@(posedge wdgClk) disable iff (!rstN)
    wdgRstReq |=> !wdgRstReq);
endmodule

bind wdg_top wdg_checker chk_i (
  .busClk(busClk), .wdgClk(wdgClk), .rstN(rstN), .busSel(busSel),
  .busWrite(busWrite), .busAddr(busAddr), .busRdata(busRdata),
  .wdgRstReq(wdgRstReq), .toCore(toCore), .fromCore(fromCore)
);

// File: tb/wdg_top_tb_top.sv
module wdg_top_tb_top;
  logic busClk = 1'b0, wdgClk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic wdgRstReq;

  int errors = 0, checks = 0;
  int pulseCount = 0;
  int wdgCyc = 0;
  int lastPulse = 0;
  bit lastValid = 1'b0;
  bit prevReq = 1'b0;
  int expQ[$];
  logic [15:0] rd;

  always #10 busClk = ~busClk;   // 50 MHz
  always #55 wdgClk = ~wdgClk;   // unrelated slow clock

  wdg_top dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge busClk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge busClk);
    busSel = 1'b0;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      rdReg(2'd3, s);
      if (s[1:0] == 2'b00) return;
    end
    check(1'b0, "R6 busy never cleared", 1, 0);
  endtask

  task automatic waitWdg(input int n);
    repeat (n) @(negedge wdgClk);
  endtask

  function automatic int period(input int code, input int rld);
    int d;
    d = (code >= 7) ? 256 : (4 << code);
    return (rld + 1) * d;
  endfunction

  // driver side of the scoreboard
  task automatic expectPeriods(input int p, input int n, input string tag);
    lastValid = 1'b0;
    for (int i = 0; i < n; i++) expQ.push_back(p);
    for (int i = 0; i < (n + 2) * p + 20 && expQ.size() != 0; i++) waitWdg(1);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete();
  endtask

  // monitor: samples away from the active edge of the watchdog clock
  always @(negedge wdgClk) begin
    wdgCyc++;
    if (prevReq && wdgRstReq) check(1'b0, "R10 request wider than one cycle", 2, 1);
    if (wdgRstReq && !prevReq) begin
      pulseCount++;
      if (lastValid && expQ.size() != 0) begin
        int e;
        e = expQ.pop_front();
        check(wdgCyc - lastPulse == e, "R9 request period", wdgCyc - lastPulse, e);
      end
      lastPulse = wdgCyc;
      lastValid = 1'b1;
    end
    prevReq = wdgRstReq;
  end

  initial begin
    fork
      begin : watchdog
        repeat (150000) @(posedge busClk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (4) @(negedge busClk);
    rstN = 1'b1;
    repeat (2) @(negedge busClk);

    rdReg(2'd3, rd); check(rd == 16'h0, "R5 status after reset", rd, 0);
    rdReg(2'd2, rd); check(rd == 16'h0, "R5 prescaler after reset", rd, 0);
    rdReg(2'd1, rd); check(rd == 16'hFFF, "R5 reload after reset", rd, 16'hFFF);

    // locked write
    wr(2'd1, 16'd9);
    rdReg(2'd3, rd); check(rd[1] == 1'b0, "R7 locked write sets no busy", rd[1], 0);
    waitWdg(10);
    rdReg(2'd1, rd); check(rd == 16'hFFF, "R7 locked write ignored", rd, 16'hFFF);

    // unlocked writes
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd9);
    rdReg(2'd3, rd); check(rd[1] == 1'b1, "R6 reload busy after write", rd[1], 1);
    waitIdle();
    rdReg(2'd1, rd); check(rd == 16'd9, "R6 reload readback", rd, 9);
    wr(2'd2, 16'd0);
    rdReg(2'd3, rd); check(rd[0] == 1'b1, "R6 prescaler busy after write", rd[0], 1);
    waitIdle();
    rdReg(2'd2, rd); check(rd == 16'd0, "R6 prescaler readback", rd, 0);

    wr(2'd0, 16'hAAAA);
    rdReg(2'd0, rd); check(rd == 16'h0, "R4 key reads zero", rd, 0);

    waitWdg(100);
    check(pulseCount == 0, "R1 no request before start", pulseCount, 0);

    wr(2'd0, 16'hCCCC);
    expectPeriods(period(0, 9), 3, "R9 periods div4 reload9 missing");

    // refresh keeps request low
    begin
      int snap;
      wr(2'd0, 16'hAAAA);
      waitWdg(8);
      snap = pulseCount;
      for (int i = 0; i < 10; i++) begin
        waitWdg(18);
        wr(2'd0, 16'hAAAA);
      end
      waitWdg(8);
      check(pulseCount == snap, "R3 refresh holds off request", pulseCount - snap, 0);
    end

    // other keys cannot stop it and re-lock
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd3);
    rdReg(2'd3, rd); check(rd[1] == 1'b0, "R7 relock sets no busy", rd[1], 0);
    expectPeriods(period(0, 9), 2, "R2 still running after other keys");
    rdReg(2'd1, rd); check(rd == 16'd9, "R7 relocked reload unchanged", rd, 9);

    // prescaler codes
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd2); wr(2'd1, 16'd3);
    waitIdle();
    expectPeriods(period(2, 3), 3, "R9 periods div16 reload3 missing");
    wr(2'd2, 16'd7); wr(2'd1, 16'd1);
    waitIdle();
    rdReg(2'd2, rd); check(rd == 16'd7, "R6 prescaler code 7 readback", rd, 7);
    expectPeriods(period(7, 1), 2, "R9 periods code7 missing");
    wr(2'd2, 16'd6);
    waitIdle();
    expectPeriods(period(6, 1), 2, "R9 periods code6 missing");

    // write while busy ignored
    wr(2'd1, 16'd5);
    wr(2'd1, 16'd7);
    waitIdle();
    rdReg(2'd1, rd); check(rd == 16'd5, "R8 write while busy ignored", rd, 5);
    expectPeriods(period(6, 5), 2, "R9 periods reload5 missing");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule